// File: doc/BRIEF.md
# Delta-Sigma Fractional Divider Controller

This block is the digital control path of a frequency-to-digital converter that uses a phase interpolator. On every reference clock cycle it takes the one-bit early/late decision of the phase quantizer and a 20-bit fractional frequency word. It maps the decision to plus or minus a programmable gain and adds the result to the word. A second-order MASH 1-1 modulator reduces that sum to a 6-bit step count. A 6-bit phase accumulator integrates the step count modulo one oscillator period, which is 64 steps.

When the accumulator wraps, it raises the select for the dual-modulus divider. Its six low bits are the interpolator code. Together, the divider and the interpolator split one oscillator period into 64 equal steps. The long-run average number of steps per reference cycle therefore follows the fractional word, and the quantizer feedback pulls it up or down.

Top module: `dsfd_ctrl`

## Requirements
- R1: A synchronous active-high reset drives `ctrl_word`, `pi_code` and `dmd_sel` to 0 and clears all modulator state.
- R2: When `pq_bit` is 1, `pq_gain` is added to `frac_word`. When it is 0, `pq_gain` is subtracted. Both values are in units of the `frac_word` LSB.
- R3: The 22-bit signed sum is read as a fixed-point value. The bits above bit 13 give whole interpolator steps and bits 13..0 give the fraction. The registered `ctrl_word` equals the whole-step part plus a modulator offset in the range −1 to +2 (modulo 64), one clock after the inputs. The caller keeps the whole-step part between 1 and 61.
- R4: Over a long window, 64 × (number of `dmd_sel` pulses) plus the change in `pi_code` equals the sum of (input sum / 2^14) over the window, within 3 steps.
- R5: On each clock, `pi_code` advances by the `ctrl_word` of the previous cycle, modulo 64.
- R6: `dmd_sel` is 1 for exactly the cycles in which that advance passes 64. In those cycles `pi_code` becomes smaller than its prior value.
- R7: When the fractional bits of the sum are zero and the modulator state is clear, `ctrl_word` equals the whole-step part exactly, with no dither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| pq_bit | input | 1 | Phase-quantizer decision, 1 = add gain, 0 = subtract gain |
| frac_word | input | 20 | Fractional frequency word, 6 whole-step bits above 14 fraction bits |
| pq_gain | input | 15 | Magnitude of the quantizer feedback term |
| ctrl_word | output | 6 | Modulated step count per reference cycle |
| dmd_sel | output | 1 | Divider modulus select, high on accumulator wrap |
| pi_code | output | 6 | Interpolator code, accumulator low bits |

## Verification
Assertions check three things on every cycle. The modulator output stays within −1..+2 of the whole-step input. The wrap flag agrees with the direction in which the interpolator code moves. Reset clears the accumulator, and an undithered input gives an exact step count. Only the bench scenarios can show the rest. These are the sign mapping of the quantizer bit, the exact code and wrap sequence for a constant step count, and the long-run average of steps that matches the fractional word, both with a toggling decision and with a fixed one.

// File: rtl/dsfd_pkg.sv
package dsfd_pkg;

    // Meaning of the one-bit phase-quantizer decision
    typedef enum logic {
        PQ_SUB = 1'b0,
        PQ_ADD = 1'b1
    } pq_pol_e;

    // Width of the signed sum that carries frequency word plus feedback
    function automatic int sum_width(input int frac_w, input int gain_w);
        return ((frac_w > gain_w) ? frac_w : gain_w) + 2;
    endfunction

endpackage

// File: rtl/dsfd_scaler.sv
module dsfd_scaler
    import dsfd_pkg::*;
#(
    parameter int FRAC_W = 20,
    parameter int GAIN_W = 15,
    localparam int SUM_W = sum_width(FRAC_W, GAIN_W)
) (
    input  logic                    pq_bit,
    input  logic [FRAC_W-1:0]       frac_word,
    input  logic [GAIN_W-1:0]       pq_gain,
    output logic signed [SUM_W-1:0] sum
);

    logic signed [SUM_W-1:0] frac_ext;
    logic signed [SUM_W-1:0] gain_ext;
    pq_pol_e                 pol;

    always_comb begin
        frac_ext = {{(SUM_W-FRAC_W){1'b0}}, frac_word};
        gain_ext = {{(SUM_W-GAIN_W){1'b0}}, pq_gain};
        pol      = pq_pol_e'(pq_bit);
        sum      = (pol == PQ_ADD) ? (frac_ext + gain_ext) : (frac_ext - gain_ext);
    end

endmodule

// File: rtl/dsfd_mash11.sv
module dsfd_mash11 #(
    parameter int SUM_W  = 22,
    parameter int RES_W  = 14,
    parameter int CODE_W = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [SUM_W-1:0] sum,
    output logic [CODE_W-1:0]       word
);

    logic [RES_W-1:0]        acc1, acc2;
    logic                    c2_d;
    logic [RES_W:0]          s1, s2;
    logic [RES_W-1:0]        resid;
    logic signed [SUM_W-1:0] whole;
    logic signed [SUM_W-1:0] offset;
    logic signed [SUM_W-1:0] word_wide;
    logic [CODE_W-1:0]       whole_low;

    always_comb begin
        resid     = sum[RES_W-1:0];
        whole     = sum >>> RES_W;
        whole_low = whole[CODE_W-1:0];
        s1        = {1'b0, acc1} + {1'b0, resid};
        s2        = {1'b0, acc2} + {1'b0, s1[RES_W-1:0]};
        offset    = SUM_W'(s1[RES_W]) + SUM_W'(s2[RES_W]) - SUM_W'(c2_d);
        word_wide = whole + offset;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc1 <= '0;
            acc2 <= '0;
            c2_d <= 1'b0;
            word <= '0;
        end else begin
            acc1 <= s1[RES_W-1:0];
            acc2 <= s2[RES_W-1:0];
            c2_d <= s2[RES_W];
            word <= word_wide[CODE_W-1:0];
        end
    end

    // R3: registered word stays within -1..+2 of the prior whole-step input
    a_r3_offset_range: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |->
        ((CODE_W'(word - $past(whole_low)) <= CODE_W'(2)) ||
         (CODE_W'(word - $past(whole_low)) == {CODE_W{1'b1}})));

    // R7: no residue and clear state give the whole-step value exactly
    a_r7_no_dither: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(resid) == '0 && $past(acc1) == '0 &&
         $past(acc2) == '0 && !$past(c2_d)) |-> (word == $past(whole_low)));

endmodule

// File: rtl/dsfd_phase_acc.sv
module dsfd_phase_acc #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] word,
    output logic [CODE_W-1:0] code,
    output logic              wrap
);

    logic [CODE_W:0] nxt;

    always_comb nxt = {1'b0, code} + {1'b0, word};

    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
            wrap <= 1'b0;
        end else begin
            code <= nxt[CODE_W-1:0];
            wrap <= nxt[CODE_W];
        end
    end

    // R1: reset clears the accumulator and the select
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (code == '0 && !wrap));

    // R6: a wrap makes the code move backwards
    a_r6_wrap_drops: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && wrap) |-> (code < $past(code)));

    // R6: no wrap means the code does not move backwards
    a_r6_hold_rises: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !wrap) |-> (code >= $past(code)));

endmodule

// File: rtl/dsfd_ctrl.sv
module dsfd_ctrl
    import dsfd_pkg::*;
#(
    parameter int FRAC_W = 20,
    parameter int GAIN_W = 15,
    parameter int CODE_W = 6,
    localparam int RES_W = FRAC_W - CODE_W,
    localparam int SUM_W = sum_width(FRAC_W, GAIN_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pq_bit,
    input  logic [FRAC_W-1:0] frac_word,
    input  logic [GAIN_W-1:0] pq_gain,
    output logic [CODE_W-1:0] ctrl_word,
    output logic              dmd_sel,
    output logic [CODE_W-1:0] pi_code
);

    logic signed [SUM_W-1:0] sum;

    dsfd_scaler #(.FRAC_W(FRAC_W), .GAIN_W(GAIN_W)) u_scaler (
        .pq_bit    (pq_bit),
        .frac_word (frac_word),
        .pq_gain   (pq_gain),
        .sum       (sum)
    );

    dsfd_mash11 #(.SUM_W(SUM_W), .RES_W(RES_W), .CODE_W(CODE_W)) u_mash (
        .clk  (clk),
        .rst  (rst),
        .sum  (sum),
        .word (ctrl_word)
    );

    dsfd_phase_acc #(.CODE_W(CODE_W)) u_acc (
        .clk  (clk),
        .rst  (rst),
        .word (ctrl_word),
        .code (pi_code),
        .wrap (dmd_sel)
    );

    // R5: code advances by the previous word modulo the step count
    a_r5_advance: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (CODE_W'(pi_code - $past(pi_code)) == $past(ctrl_word)));

endmodule

// File: tb/dsfd_ctrl_tb.sv
module dsfd_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pq_bit = 1'b0;
    logic [19:0] frac_word = '0;
    logic [14:0] pq_gain = '0;
    logic [5:0]  ctrl_word;
    logic        dmd_sel;
    logic [5:0]  pi_code;

    int n_chk  = 0;
    int n_fail = 0;

    always #2ns clk = ~clk;

    dsfd_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .pq_bit    (pq_bit),
        .frac_word (frac_word),
        .pq_gain   (pq_gain),
        .ctrl_word (ctrl_word),
        .dmd_sel   (dmd_sel),
        .pi_code   (pi_code)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // R1: outputs cleared by reset after activity
    task automatic t_reset();
        frac_word = 20'h53A7B; pq_gain = 15'd3000; pq_bit = 1'b1;
        rst = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(ctrl_word == 6'd0, "R1 ctrl_word", ctrl_word, 0);
        check(pi_code == 6'd0,   "R1 pi_code", pi_code, 0);
        check(dmd_sel == 1'b0,   "R1 dmd_sel", dmd_sel, 0);
    endtask

    // R2: quantizer bit sign mapping, undithered (R7)
    task automatic t_sign();
        do_reset();
        frac_word = 20'h40000; pq_gain = 15'd16384; pq_bit = 1'b1;
        @(negedge clk);
        check(ctrl_word == 6'd17, "R2 add gain", ctrl_word, 17);
        pq_bit = 1'b0;
        @(negedge clk);
        check(ctrl_word == 6'd15, "R2 subtract gain", ctrl_word, 15);
        pq_gain = 15'd0;
        @(negedge clk);
        check(ctrl_word == 6'd16, "R7 exact whole step", ctrl_word, 16);
    endtask

    // R5 R6: exact code and wrap sequence for constant word 40
    task automatic t_sequence();
        logic [5:0] exp_code [6] = '{6'd0, 6'd40, 6'd16, 6'd56, 6'd32, 6'd8};
        bit         exp_wrap [6] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
        do_reset();
        frac_word = 20'hA0000; pq_gain = 15'd0; pq_bit = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(pi_code == exp_code[i], "R5 pi_code step", pi_code, exp_code[i]);
            check(dmd_sel == exp_wrap[i], "R6 dmd_sel wrap", dmd_sel, exp_wrap[i]);
        end
    endtask

    // R3: dithered word stays within -1..+2 of whole part 20
    task automatic t_range();
        int bad = 0;
        int last = 0;
        do_reset();
        frac_word = 20'h53A7B; pq_gain = 15'd0; pq_bit = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (ctrl_word < 6'd19 || ctrl_word > 6'd22) begin
                bad++;
                last = ctrl_word;
            end
        end
        check(bad == 0, "R3 word range 19..22", last, 20);
    endtask

    // R4: long-run average of steps follows the input
    task automatic t_average(input logic [19:0] fw, input logic [14:0] g, input bit toggle, input string tag);
        longint carries = 0;
        longint p0, p1, steps, expect_fx, err;
        int n = 4096;
        do_reset();
        frac_word = fw; pq_gain = g; pq_bit = 1'b1;
        repeat (50) @(negedge clk) if (toggle) pq_bit = ~pq_bit;
        p0 = pi_code;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (dmd_sel) carries++;
            if (toggle) pq_bit = ~pq_bit;
        end
        p1 = pi_code;
        steps = 64 * carries + p1 - p0;
        expect_fx = longint'(n) * (longint'(fw) + (toggle ? 0 : longint'(g)));
        err = steps * 16384 - expect_fx;
        if (err < 0) err = -err;
        check(err <= 3 * 16384, tag, steps, expect_fx / 16384);
    endtask

    initial begin
        #(200000 * 4ns);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_sign();
        t_sequence();
        t_range();
        t_average(20'h53A7B, 15'd9000, 1'b1, "R4 average toggling decision");
        t_average(20'h2C0F1, 15'd5000, 1'b0, "R4 average fixed decision");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule